// File: doc/BRIEF.md
# Memory-Tagging Control Register with Access Gate

This block holds the 64-bit control word that configures memory-tag generation. Software reaches it through system-register read and write requests. Each request carries a five-field register encoding (op0, op1, CRn, CRm, op2), a read/write flag, write data and the exception level of the requester.

The block checks the encoding and then applies an ordered set of permission checks. These checks use the feature-present input, whether EL2 is enabled, whether EL3 exists, one enable bit in the hypervisor configuration word and one enable bit in the secure configuration word. The result is one of four outcomes: the access completes, it is undefined, it traps to EL2, or it traps to EL3. The block returns the result as a one-hot code in the same cycle as the request, together with the read data. A permitted write takes effect on the next clock edge.

Only two fields are live:
- a 16-bit tag exclusion mask in bits 15:0;
- a random-generation control flag in bit 16.

All other bits read as zero and cannot be written.

Top module: `tagctl_reg`

## Requirements
- R1: Only the encoding op0=3, op1=0, CRn=1, CRm=0, op2=6 selects the register. Any other encoding gives result UNDEF (4'b0010), and a write with such an encoding leaves the register unchanged.
- R2: Bits 15:0 (exclusion mask) and bit 16 (random-generation flag) are writable and read back as written. Bits 63:17 always read as zero, and writes to them are discarded.
- R3: After reset the register holds all zeros.
- R4: Any access with req_el=0 (EL0) gives result UNDEF.
- R5: When feat_present is 0, every access gives result UNDEF, whatever the trap conditions are.
- R6: For an access with req_el=1, if el2_enabled is 1 and hyp_cfg[56] is 0, the result is TRAP_EL2 (4'b0100).
- R7: For an access with req_el=1 that passes the EL2 check, if el3_present is 1 and sec_cfg[26] is 0, the result is TRAP_EL3 (4'b1000). If neither check fires, the result is DONE (4'b0001).
- R8: For an access with req_el=2, the result is TRAP_EL3 when el3_present is 1 and sec_cfg[26] is 0, and DONE otherwise. hyp_cfg has no effect on this outcome.
- R9: For an access with req_el=3 and the feature present, the result is DONE.
- R10: A write whose result is not DONE leaves the register unchanged. A read whose result is not DONE returns zero data, and a write request always returns zero data.
- R11: rsp_code and rsp_rdata are valid combinationally in the request cycle. rsp_code is 4'b0000 when req_valid is 0 and one-hot otherwise. A DONE write updates the register at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Exception level of the requester (0..3) |
| req_wdata | input | 64 | Write data |
| feat_present | input | 1 | Tagging feature implemented |
| el2_enabled | input | 1 | EL2 is enabled for the requester |
| el3_present | input | 1 | EL3 is implemented |
| hyp_cfg | input | 64 | Hypervisor configuration word (bit 56 = tag access enable) |
| sec_cfg | input | 64 | Secure configuration word (bit 26 = tag access enable) |
| rsp_code | output | 4 | One-hot result: DONE, UNDEF, TRAP_EL2 or TRAP_EL3 |
| rsp_rdata | output | 64 | Read data |

## Verification
The result code and the read data depend only on the present inputs and the stored word, so they are due in the request cycle itself. The bench drives each request on the falling edge and compares the outputs 5 ns later, before the next rising edge. A permitted write changes the stored word at the following rising edge. The reference model updates its own copy only after that edge, so the effect of every write shows up in the read requests that follow it. Directed requests cover each rung of the priority order, and a randomized sweep then mixes encodings, levels and configuration words.

// File: rtl/tagctl_pkg.sv
package tagctl_pkg;
    localparam int DATA_W   = 64;
    localparam int MASK_W   = 16;
    localparam int LIVE_W   = MASK_W + 1;
    localparam int HYP_EN_BIT = 56;
    localparam int SEC_EN_BIT = 26;

    typedef enum logic [3:0] {
        RES_IDLE     = 4'b0000,
        RES_DONE     = 4'b0001,
        RES_UNDEF    = 4'b0010,
        RES_TRAP_EL2 = 4'b0100,
        RES_TRAP_EL3 = 4'b1000
    } result_e;

    typedef enum logic [1:0] {
        LVL_EL0 = 2'd0,
        LVL_EL1 = 2'd1,
        LVL_EL2 = 2'd2,
        LVL_EL3 = 2'd3
    } level_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;
endpackage

// File: rtl/tagctl_decode.sv
module tagctl_decode #(
    parameter logic [1:0] SEL_OP0 = 2'd3,
    parameter logic [2:0] SEL_OP1 = 3'd0,
    parameter logic [3:0] SEL_CRN = 4'd1,
    parameter logic [3:0] SEL_CRM = 4'd0,
    parameter logic [2:0] SEL_OP2 = 3'd6
) (
    input  tagctl_pkg::sysenc_t enc,
    output logic                hit
);
    localparam tagctl_pkg::sysenc_t SEL = '{op0: SEL_OP0, op1: SEL_OP1,
                                            crn: SEL_CRN, crm: SEL_CRM,
                                            op2: SEL_OP2};
    always_comb begin
        hit = (enc == SEL);
    end
endmodule

// File: rtl/tagctl_gate.sv
module tagctl_gate
    import tagctl_pkg::*;
(
    input  logic    valid,
    input  logic    hit,
    input  level_e  lvl,
    input  logic    feat_present,
    input  logic    el2_enabled,
    input  logic    el3_present,
    input  logic    hyp_en,
    input  logic    sec_en,
    output result_e res
);
    logic sec_block;
    logic hyp_block;

    always_comb begin
        sec_block = el3_present && !sec_en;
        hyp_block = el2_enabled && !hyp_en;
    end

    always_comb begin
        res = RES_IDLE;
        if (valid) begin
            if (!feat_present || !hit) begin
                res = RES_UNDEF;
            end else begin
                unique case (lvl)
                    LVL_EL0: res = RES_UNDEF;
                    LVL_EL1: begin
                        if (hyp_block)      res = RES_TRAP_EL2;
                        else if (sec_block) res = RES_TRAP_EL3;
                        else                res = RES_DONE;
                    end
                    LVL_EL2: begin
                        if (sec_block)      res = RES_TRAP_EL3;
                        else                res = RES_DONE;
                    end
                    LVL_EL3: res = RES_DONE;
                    default: res = RES_UNDEF;
                endcase
            end
        end
    end
endmodule

// File: rtl/tagctl_store.sv
module tagctl_store #(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end
endmodule

// File: rtl/tagctl_reg.sv
module tagctl_reg
    import tagctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [1:0]  req_el,
    input  logic [63:0] req_wdata,
    input  logic        feat_present,
    input  logic        el2_enabled,
    input  logic        el3_present,
    input  logic [63:0] hyp_cfg,
    input  logic [63:0] sec_cfg,
    output logic [3:0]  rsp_code,
    output logic [63:0] rsp_rdata
);
    sysenc_t           enc;
    logic              hit;
    result_e           res;
    logic              granted;
    logic              wr_en;
    logic [LIVE_W-1:0] reg_q;
    logic              unused_bits;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn,
                   crm: req_crm, op2: req_op2};
    assign unused_bits = ^{hyp_cfg, sec_cfg, req_wdata[DATA_W-1:LIVE_W]};

    tagctl_decode u_decode (
        .enc (enc),
        .hit (hit)
    );

    tagctl_gate u_gate (
        .valid        (req_valid),
        .hit          (hit),
        .lvl          (level_e'(req_el)),
        .feat_present (feat_present),
        .el2_enabled  (el2_enabled),
        .el3_present  (el3_present),
        .hyp_en       (hyp_cfg[HYP_EN_BIT]),
        .sec_en       (sec_cfg[SEC_EN_BIT]),
        .res          (res)
    );

    assign granted = (res == RES_DONE);
    assign wr_en   = granted && req_write;

    tagctl_store #(.WIDTH(LIVE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (req_wdata[LIVE_W-1:0]),
        .q       (reg_q)
    );

    always_comb begin
        rsp_code  = res;
        rsp_rdata = '0;
        if (granted && !req_write)
            rsp_rdata[LIVE_W-1:0] = reg_q;
    end
endmodule

// File: rtl/tagctl_chk.sv
module tagctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_el,
    input logic [63:0] req_wdata,
    input logic        feat_present,
    input logic [3:0]  rsp_code,
    input logic [63:0] rsp_rdata,
    input logic [16:0] reg_q
);
    // R11
    code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(rsp_code) == 1);
    // R11
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> rsp_code == 4'b0000);
    // R4
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd0) |-> rsp_code == 4'b0010);
    // R5
    no_feat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_present) |-> rsp_code == 4'b0010);
    // R10
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rsp_code != 4'b0001) |=> $stable(reg_q));
    // R11
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rsp_code == 4'b0001) |=> reg_q == $past(req_wdata[16:0]));
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[63:17] == '0);
    // R10
    blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 4'b0001 || req_write) |-> rsp_rdata == '0);
endmodule

bind tagctl_reg tagctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_el       (req_el),
    .req_wdata    (req_wdata),
    .feat_present (feat_present),
    .rsp_code     (rsp_code),
    .rsp_rdata    (rsp_rdata),
    .reg_q        (reg_q)
);

// File: tb/tagctl_reg_tb.sv
module tagctl_reg_tb;
    localparam time CLK_P = 20ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [1:0]  req_op0 = 0;
    logic [2:0]  req_op1 = 0;
    logic [3:0]  req_crn = 0;
    logic [3:0]  req_crm = 0;
    logic [2:0]  req_op2 = 0;
    logic [1:0]  req_el = 0;
    logic [63:0] req_wdata = 0;
    logic        feat_present = 1;
    logic        el2_enabled = 0;
    logic        el3_present = 0;
    logic [63:0] hyp_cfg = 0;
    logic [63:0] sec_cfg = 0;
    logic [3:0]  rsp_code;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [63:0] model = 0;

    always #(CLK_P/2) clk = ~clk;

    tagctl_reg u_dut (.*);

    function automatic logic [3:0] exp_code();
        if (!req_valid) return 4'b0000;
        if (!feat_present) return 4'b0010;
        if (!(req_op0 == 3 && req_op1 == 0 && req_crn == 1 && req_crm == 0 && req_op2 == 6))
            return 4'b0010;
        case (req_el)
            2'd0: return 4'b0010;
            2'd1: begin
                if (el2_enabled && !hyp_cfg[56]) return 4'b0100;
                if (el3_present && !sec_cfg[26]) return 4'b1000;
                return 4'b0001;
            end
            2'd2: return (el3_present && !sec_cfg[26]) ? 4'b1000 : 4'b0001;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [3:0]  ec;
        logic [63:0] ed;
        #5;
        ec = exp_code();
        ed = (ec == 4'b0001 && !req_write) ? model : 64'd0;
        check({tag, " code"}, {60'd0, rsp_code}, {60'd0, ec});
        check({tag, " rdata"}, rsp_rdata, ed);
        @(posedge clk);
        if (ec == 4'b0001 && req_write) model = {47'd0, req_wdata[16:0]};
        @(negedge clk);
    endtask

    task automatic set_enc_ok();
        req_op0 = 3; req_op1 = 0; req_crn = 1; req_crm = 0; req_op2 = 6;
    endtask

    task automatic acc(input logic w, input logic [1:0] el, input logic [63:0] d, input string tag);
        req_valid = 1; req_write = w; req_el = el; req_wdata = d;
        step(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_enc_ok();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 idle, R3 reset value
        req_valid = 0; step("R11 idle");
        acc(0, 3, 0, "R3 reset read");
        // R2 live fields and upper bits dropped
        acc(1, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R2 write all ones");
        acc(0, 3, 0, "R2 readback 1FFFF");
        acc(1, 3, 64'hABCD_0000_0000_A5C3, "R2 write mask");
        acc(0, 3, 0, "R2 readback A5C3");
        // R1 wrong encoding
        req_op2 = 5; acc(1, 3, 64'h1234, "R1 bad op2 write");
        set_enc_ok(); req_crn = 2; acc(0, 3, 0, "R1 bad crn read");
        set_enc_ok(); acc(0, 3, 0, "R1 unchanged");
        // R4 EL0
        acc(1, 0, 64'h1, "R4 EL0 write"); acc(0, 3, 0, "R4 unchanged");
        // R6 EL1 trap to EL2
        el2_enabled = 1; el3_present = 1; hyp_cfg = 0; sec_cfg = 0;
        acc(1, 1, 64'h7, "R6 EL1 trap EL2 priority"); acc(0, 3, 0, "R10 unchanged after trap");
        // R7 EL1 trap to EL3
        hyp_cfg[56] = 1; acc(0, 1, 0, "R7 EL1 trap EL3");
        sec_cfg[26] = 1; acc(1, 1, 64'h10001, "R7 EL1 done write"); acc(0, 1, 0, "R7 EL1 read");
        el2_enabled = 0; hyp_cfg = 0; acc(0, 1, 0, "R6 EL2 disabled passes");
        // R8 EL2 ignores hyp bit
        el2_enabled = 1; hyp_cfg = 0; sec_cfg = 0; acc(1, 2, 64'h3, "R8 EL2 trap EL3");
        sec_cfg[26] = 1; acc(1, 2, 64'h3, "R8 EL2 done hyp ignored"); acc(0, 2, 0, "R8 readback");
        el3_present = 0; sec_cfg = 0; acc(0, 2, 0, "R8 no EL3 done");
        // R9 EL3 always done
        el3_present = 1; acc(1, 3, 64'hF0F0, "R9 EL3 write");
        // R5 feature absent beats traps
        feat_present = 0; acc(1, 1, 64'h55, "R5 no feature EL1"); acc(0, 3, 0, "R5 no feature EL3");
        feat_present = 1; acc(0, 3, 0, "R10 unchanged after undef");
        // randomized sweep
        for (int i = 0; i < 400; i++) begin
            req_valid = ($urandom_range(0, 7) != 0);
            req_write = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) begin
                req_op0 = $urandom; req_op1 = $urandom; req_crn = $urandom;
                req_crm = $urandom; req_op2 = $urandom;
            end else set_enc_ok();
            req_el = $urandom; req_wdata = {$urandom, $urandom};
            feat_present = ($urandom_range(0, 5) != 0);
            el2_enabled = $urandom; el3_present = $urandom;
            hyp_cfg = {$urandom, $urandom}; sec_cfg = {$urandom, $urandom};
            step("R1 R6 R7 R8 R10 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule